// File: doc/BRIEF.md
# Contended-Line Requestor Queue with Early Value Relay

This block sits beside a coherence directory. It orders exclusive-ownership requests for heavily contended lines. A small pool of queues is kept, and each queue is bound to one line address. A queue holds the IDs of the cores waiting for that line, oldest first. The core at the head owns the line. Other cores are granted the line only when the owner reports that its compare-and-swap is done and releases the line.

The same structure relays values early. A queued core may send the new value of its pending compare-and-swap, together with a word offset, before that operation completes. The value is stored in the core's own queue entry and passed on at once to the core queued directly behind it. That core can then start its own work speculatively instead of waiting for the line. A value that arrives before any successor exists is kept in its entry. It is relayed when the next core enqueues.

All traffic enters through one message port, one message per cycle. Grants and relayed values leave through two registered output channels, one cycle after the message that causes them.

Top module: `dq_relay_top`

## Requirements
- R1: After reset no queue is in use and both output channels are idle (grantValid and fwdValid low).
- R2: A request (kind 1) for an address held by no queue, while some queue is free, binds the lowest free queue to that address with the requester as its only entry. The requester is granted (grantValid, grantCore, grantAddr) in the cycle after the message.
- R3: A request for an address already held by a queue appends the requester to the tail of that queue and produces no grant.
- R4: A release (kind 2) from the head core of a queue removes the head. If other entries remain, the new head is granted one cycle later. A release from any core that is not the head has no effect.
- R5: When the last entry of a queue is removed, the queue becomes free, and a later request for any address can claim it again.
- R6: A request for an address held by no queue, when no queue is free, is granted one cycle later without being queued. A later release for that address has no effect.
- R7: A request to a queue that already holds DEPTH entries is dropped. It causes no grant, no relay and no enqueue.
- R8: A forward message (kind 3) from a core queued on the addressed line stores its offset and value in that core's entry. If an entry follows it, offset, value and address go to that following core only, one cycle later.
- R9: A stored value with no successor is held. When a core next enqueues behind it, the held offset and value go to that new core one cycle after its request.
- R10: A forward message from a core that is not queued on the addressed line, or for an address held by no queue, produces no output and changes no queue.
- R11: Queues bound to different addresses operate independently, and no two queues are ever bound to the same address.
- R12: A release never produces a relayed value.
- R13: Each output pulse lasts exactly one cycle, and no output is raised in a cycle that follows a cycle without a message (message kind 0 or msgValid low).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| msgValid | input | 1 | A message is present this cycle |
| msgKind | input | 2 | 0 none, 1 request, 2 release, 3 forward |
| msgCore | input | CORE_W | Sending core ID |
| msgAddr | input | ADDR_W | Line address |
| msgOff | input | OFF_W | Word offset of a forwarded value |
| msgVal | input | VAL_W | Forwarded value |
| grantValid | output | 1 | Grant pulse |
| grantCore | output | CORE_W | Core receiving the line |
| grantAddr | output | ADDR_W | Granted line address |
| fwdValid | output | 1 | Relayed-value pulse |
| fwdCore | output | CORE_W | Core receiving the value |
| fwdAddr | output | ADDR_W | Line the value belongs to |
| fwdOff | output | OFF_W | Word offset of the value |
| fwdVal | output | VAL_W | Relayed value |

## Verification
The main sequence runs one line through its whole life: first request, queued followers, a forward that has a successor, a forward with none that is relayed later, an overflow request, and releases from the head and from a non-head core. The waiters must come out in FIFO order, and each relayed value must reach only the immediate successor. Pool exhaustion is driven with a third address while two lines are busy. This separates queued service from pass-through grants, and it shows that a freed queue is reusable. A reset in mid-flight followed by a request for a still-busy line checks that reset drops all queue state.

// File: rtl/dq_pkg.sv
package dq_pkg;
  typedef enum logic [1:0] {
    MSG_NONE = 2'd0,
    MSG_REQ  = 2'd1,
    MSG_REL  = 2'd2,
    MSG_FWD  = 2'd3
  } msgKind_e;

  // strobes from control to datapath; at most one set per cycle
  typedef struct packed {
    logic alloc;
    logic push;
    logic pop;
    logic store;
  } dqStrobe_t;
endpackage

// File: rtl/dq_store.sv
module dq_store
  import dq_pkg::*;
#(
  parameter int NQ     = 4,
  parameter int DEPTH  = 4,
  parameter int CORE_W = 4,
  parameter int ADDR_W = 16,
  parameter int OFF_W  = 3,
  parameter int VAL_W  = 32,
  parameter int QI_W   = 2,
  parameter int POS_W  = 2,
  parameter int CNT_W  = 3
) (
  input  logic                                 clk,
  input  logic                                 rstN,
  input  dqStrobe_t                            strobe,
  input  logic [QI_W-1:0]                      qSel,
  input  logic [POS_W-1:0]                     storePos,
  input  logic [CORE_W-1:0]                    inCore,
  input  logic [ADDR_W-1:0]                    inAddr,
  input  logic [OFF_W-1:0]                     inOff,
  input  logic [VAL_W-1:0]                     inVal,
  output logic [NQ-1:0]                        qValid,
  output logic [NQ-1:0][ADDR_W-1:0]            qAddr,
  output logic [NQ-1:0][CNT_W-1:0]             qCount,
  output logic [NQ-1:0][DEPTH-1:0][CORE_W-1:0] entCore,
  output logic [NQ-1:0][DEPTH-1:0]             entHas,
  output logic [NQ-1:0][DEPTH-1:0][OFF_W-1:0]  entOff,
  output logic [NQ-1:0][DEPTH-1:0][VAL_W-1:0]  entVal
);
  for (genvar q = 0; q < NQ; q++) begin : g_queue
    logic                          vld;
    logic [ADDR_W-1:0]             adr;
    logic [CNT_W-1:0]              cnt;
    logic [DEPTH-1:0][CORE_W-1:0]  cor;
    logic [DEPTH-1:0]              has;
    logic [DEPTH-1:0][OFF_W-1:0]   off;
    logic [DEPTH-1:0][VAL_W-1:0]   val;
    logic                          mine;
    logic [POS_W-1:0]              tailPos;

    assign mine    = (qSel == QI_W'(q));
    assign tailPos = POS_W'(cnt);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        vld <= 1'b0;
        adr <= '0;
        cnt <= '0;
        cor <= '0;
        has <= '0;
        off <= '0;
        val <= '0;
      end else if (mine) begin
        if (strobe.alloc) begin
          vld    <= 1'b1;
          adr    <= inAddr;
          cnt    <= CNT_W'(1);
          cor[0] <= inCore;
          has    <= '0;
        end else if (strobe.push) begin
          cor[tailPos] <= inCore;
          has[tailPos] <= 1'b0;
          cnt          <= cnt + CNT_W'(1);
        end else if (strobe.pop) begin
          for (int j = 0; j < DEPTH - 1; j++) begin
            cor[j] <= cor[j+1];
            has[j] <= has[j+1];
            off[j] <= off[j+1];
            val[j] <= val[j+1];
          end
          has[DEPTH-1] <= 1'b0;
          cnt          <= cnt - CNT_W'(1);
          if (cnt == CNT_W'(1)) vld <= 1'b0;
        end else if (strobe.store) begin
          off[storePos] <= inOff;
          val[storePos] <= inVal;
          has[storePos] <= 1'b1;
        end
      end
    end

    assign qValid[q]  = vld;
    assign qAddr[q]   = adr;
    assign qCount[q]  = cnt;
    assign entCore[q] = cor;
    assign entHas[q]  = has;
    assign entOff[q]  = off;
    assign entVal[q]  = val;

    // R7: the control never lets a queue grow past its depth
    p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rstN)
      cnt <= CNT_W'(DEPTH));
    // R5: a queue is in use exactly while it has entries
    p_count_valid_r5: assert property (@(posedge clk) disable iff (!rstN)
      vld == (cnt != '0));
    // R2: only a free queue is ever bound
    p_alloc_free_r2: assert property (@(posedge clk) disable iff (!rstN)
      (strobe.alloc && mine) |-> !vld);
  end

  // R11: no two queues share an address
  for (genvar a = 0; a < NQ; a++) begin : g_ua
    for (genvar b = a + 1; b < NQ; b++) begin : g_ub
      p_unique_addr_r11: assert property (@(posedge clk) disable iff (!rstN)
        !(qValid[a] && qValid[b] && qAddr[a] == qAddr[b]));
    end
  end
endmodule

// File: rtl/dq_ctrl.sv
module dq_ctrl
  import dq_pkg::*;
#(
  parameter int NQ     = 4,
  parameter int DEPTH  = 4,
  parameter int CORE_W = 4,
  parameter int ADDR_W = 16,
  parameter int OFF_W  = 3,
  parameter int VAL_W  = 32,
  parameter int QI_W   = 2,
  parameter int POS_W  = 2,
  parameter int CNT_W  = 3
) (
  input  logic                                 clk,
  input  logic                                 rstN,
  input  logic                                 msgValid,
  input  msgKind_e                             msgKind,
  input  logic [CORE_W-1:0]                    msgCore,
  input  logic [ADDR_W-1:0]                    msgAddr,
  input  logic [OFF_W-1:0]                     msgOff,
  input  logic [VAL_W-1:0]                     msgVal,
  input  logic [NQ-1:0]                        qValid,
  input  logic [NQ-1:0][ADDR_W-1:0]            qAddr,
  input  logic [NQ-1:0][CNT_W-1:0]             qCount,
  input  logic [NQ-1:0][DEPTH-1:0][CORE_W-1:0] entCore,
  input  logic [NQ-1:0][DEPTH-1:0]             entHas,
  input  logic [NQ-1:0][DEPTH-1:0][OFF_W-1:0]  entOff,
  input  logic [NQ-1:0][DEPTH-1:0][VAL_W-1:0]  entVal,
  output dqStrobe_t                            strobe,
  output logic [QI_W-1:0]                      qSel,
  output logic [POS_W-1:0]                     storePos,
  output logic                                 grantValid,
  output logic [CORE_W-1:0]                    grantCore,
  output logic [ADDR_W-1:0]                    grantAddr,
  output logic                                 fwdValid,
  output logic [CORE_W-1:0]                    fwdCore,
  output logic [ADDR_W-1:0]                    fwdAddr,
  output logic [OFF_W-1:0]                     fwdOff,
  output logic [VAL_W-1:0]                     fwdVal
);
  logic                         hitAny, freeAny, posFound;
  logic [QI_W-1:0]              hitIdx, freeIdx;
  logic [POS_W-1:0]             posIdx, tailIdx;
  logic [CNT_W-1:0]             selCnt;
  logic [DEPTH-1:0][CORE_W-1:0] selCore;
  logic [DEPTH-1:0]             selHas;
  logic                         nGrant, nFwd;
  logic [CORE_W-1:0]            nGrantCore, nFwdCore;
  logic [OFF_W-1:0]             nFwdOff;
  logic [VAL_W-1:0]             nFwdVal;

  // address match and lowest free queue
  always_comb begin
    hitAny  = 1'b0;
    hitIdx  = '0;
    freeAny = 1'b0;
    freeIdx = '0;
    for (int q = NQ - 1; q >= 0; q--) begin
      if (qValid[q] && qAddr[q] == msgAddr) begin
        hitAny = 1'b1;
        hitIdx = QI_W'(q);
      end
      if (!qValid[q]) begin
        freeAny = 1'b1;
        freeIdx = QI_W'(q);
      end
    end
  end

  assign selCnt  = qCount[hitIdx];
  assign selCore = entCore[hitIdx];
  assign selHas  = entHas[hitIdx];
  assign tailIdx = POS_W'(selCnt - CNT_W'(1));

  // position of the sender inside the matched queue
  always_comb begin
    posFound = 1'b0;
    posIdx   = '0;
    for (int j = DEPTH - 1; j >= 0; j--) begin
      if (CNT_W'(j) < selCnt && selCore[j] == msgCore) begin
        posFound = 1'b1;
        posIdx   = POS_W'(j);
      end
    end
  end

  always_comb begin
    strobe     = '0;
    qSel       = hitAny ? hitIdx : freeIdx;
    storePos   = posIdx;
    nGrant     = 1'b0;
    nGrantCore = msgCore;
    nFwd       = 1'b0;
    nFwdCore   = msgCore;
    nFwdOff    = msgOff;
    nFwdVal    = msgVal;
    if (msgValid) begin
      unique case (msgKind)
        MSG_REQ: begin
          if (hitAny) begin
            if (selCnt < CNT_W'(DEPTH)) begin
              strobe.push = 1'b1;
              if (selHas[tailIdx]) begin
                nFwd    = 1'b1;
                nFwdOff = entOff[hitIdx][tailIdx];
                nFwdVal = entVal[hitIdx][tailIdx];
              end
            end
          end else begin
            strobe.alloc = freeAny;
            nGrant       = 1'b1;
          end
        end
        MSG_REL: begin
          if (hitAny && selCore[0] == msgCore) begin
            strobe.pop = 1'b1;
            if (selCnt > CNT_W'(1)) begin
              nGrant     = 1'b1;
              nGrantCore = selCore[1];
            end
          end
        end
        MSG_FWD: begin
          if (hitAny && posFound) begin
            strobe.store = 1'b1;
            if (CNT_W'(posIdx) + CNT_W'(1) < selCnt) begin
              nFwd     = 1'b1;
              nFwdCore = selCore[POS_W'(posIdx + POS_W'(1))];
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      grantValid <= 1'b0;
      grantCore  <= '0;
      grantAddr  <= '0;
      fwdValid   <= 1'b0;
      fwdCore    <= '0;
      fwdAddr    <= '0;
      fwdOff     <= '0;
      fwdVal     <= '0;
    end else begin
      grantValid <= nGrant;
      grantCore  <= nGrantCore;
      grantAddr  <= msgAddr;
      fwdValid   <= nFwd;
      fwdCore    <= nFwdCore;
      fwdAddr    <= msgAddr;
      fwdOff     <= nFwdOff;
      fwdVal     <= nFwdVal;
    end
  end

  // R13: outputs only follow a cycle carrying a message
  p_out_after_msg_r13: assert property (@(posedge clk) disable iff (!rstN)
    (grantValid || fwdValid) |-> $past(msgValid && msgKind != MSG_NONE));
  // R12: a release never yields a relayed value
  p_rel_no_fwd_r12: assert property (@(posedge clk) disable iff (!rstN)
    $past(msgValid && msgKind == MSG_REL) |-> !fwdValid);
  // R2: a grant caused by a request goes to the requester
  p_req_grant_core_r2: assert property (@(posedge clk) disable iff (!rstN)
    ($past(msgValid && msgKind == MSG_REQ) && grantValid) |-> grantCore == $past(msgCore));
endmodule

// File: rtl/dq_relay_top.sv
module dq_relay_top
  import dq_pkg::*;
#(
  parameter int NQ     = 4,
  parameter int DEPTH  = 4,
  parameter int CORE_W = 4,
  parameter int ADDR_W = 16,
  parameter int OFF_W  = 3,
  parameter int VAL_W  = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              msgValid,
  input  logic [1:0]        msgKind,
  input  logic [CORE_W-1:0] msgCore,
  input  logic [ADDR_W-1:0] msgAddr,
  input  logic [OFF_W-1:0]  msgOff,
  input  logic [VAL_W-1:0]  msgVal,
  output logic              grantValid,
  output logic [CORE_W-1:0] grantCore,
  output logic [ADDR_W-1:0] grantAddr,
  output logic              fwdValid,
  output logic [CORE_W-1:0] fwdCore,
  output logic [ADDR_W-1:0] fwdAddr,
  output logic [OFF_W-1:0]  fwdOff,
  output logic [VAL_W-1:0]  fwdVal
);
  localparam int QI_W  = (NQ > 1) ? $clog2(NQ) : 1;
  localparam int POS_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  dqStrobe_t                            strobe;
  logic [QI_W-1:0]                      qSel;
  logic [POS_W-1:0]                     storePos;
  logic [NQ-1:0]                        qValid;
  logic [NQ-1:0][ADDR_W-1:0]            qAddr;
  logic [NQ-1:0][CNT_W-1:0]             qCount;
  logic [NQ-1:0][DEPTH-1:0][CORE_W-1:0] entCore;
  logic [NQ-1:0][DEPTH-1:0]             entHas;
  logic [NQ-1:0][DEPTH-1:0][OFF_W-1:0]  entOff;
  logic [NQ-1:0][DEPTH-1:0][VAL_W-1:0]  entVal;

  dq_ctrl #(.NQ(NQ), .DEPTH(DEPTH), .CORE_W(CORE_W), .ADDR_W(ADDR_W), .OFF_W(OFF_W),
            .VAL_W(VAL_W), .QI_W(QI_W), .POS_W(POS_W), .CNT_W(CNT_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .msgValid(msgValid), .msgKind(msgKind_e'(msgKind)),
    .msgCore(msgCore), .msgAddr(msgAddr), .msgOff(msgOff), .msgVal(msgVal),
    .qValid(qValid), .qAddr(qAddr), .qCount(qCount), .entCore(entCore),
    .entHas(entHas), .entOff(entOff), .entVal(entVal),
    .strobe(strobe), .qSel(qSel), .storePos(storePos),
    .grantValid(grantValid), .grantCore(grantCore), .grantAddr(grantAddr),
    .fwdValid(fwdValid), .fwdCore(fwdCore), .fwdAddr(fwdAddr),
    .fwdOff(fwdOff), .fwdVal(fwdVal));

  dq_store #(.NQ(NQ), .DEPTH(DEPTH), .CORE_W(CORE_W), .ADDR_W(ADDR_W), .OFF_W(OFF_W),
             .VAL_W(VAL_W), .QI_W(QI_W), .POS_W(POS_W), .CNT_W(CNT_W)) store_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .qSel(qSel), .storePos(storePos),
    .inCore(msgCore), .inAddr(msgAddr), .inOff(msgOff), .inVal(msgVal),
    .qValid(qValid), .qAddr(qAddr), .qCount(qCount), .entCore(entCore),
    .entHas(entHas), .entOff(entOff), .entVal(entVal));
endmodule

// File: tb/dq_relay_top_tb_top.sv
module dq_relay_top_tb_top;
  localparam int NQ = 2, DEPTH = 3, CORE_W = 4, ADDR_W = 8, OFF_W = 3, VAL_W = 16;

  typedef struct packed {
    logic [1:0]        kind;
    logic [CORE_W-1:0] core;
    logic [ADDR_W-1:0] addr;
    logic [OFF_W-1:0]  off;
    logic [VAL_W-1:0]  val;
    logic              eG;
    logic [CORE_W-1:0] eGc;
    logic              eF;
    logic [CORE_W-1:0] eFc;
    logic [OFF_W-1:0]  eFo;
    logic [VAL_W-1:0]  eFv;
  } vec_t;

  localparam int NV = 19;
  // kind: 1 request, 2 release, 3 forward
  localparam vec_t VECS [NV] = '{
    '{2'd1, 4'd1, 8'h10, 3'd0, 16'h0,    1'b1, 4'd1, 1'b0, 4'd0, 3'd0, 16'h0},
    '{2'd1, 4'd2, 8'h10, 3'd0, 16'h0,    1'b0, 4'd0, 1'b0, 4'd0, 3'd0, 16'h0},
    '{2'd3, 4'd1, 8'h10, 3'd2, 16'h1111, 1'b0, 4'd0, 1'b1, 4'd2, 3'd2, 16'h1111},
    '{2'd3, 4'd2, 8'h10, 3'd5, 16'h2222, 1'b0, 4'd0, 1'b0, 4'd0, 3'd0, 16'h0},
    '{2'd1, 4'd3, 8'h10, 3'd0, 16'h0,    1'b0, 4'd0, 1'b1, 4'd3, 3'd5, 16'h2222},
    '{2'd1, 4'd4, 8'h10, 3'd0, 16'h0,    1'b0, 4'd0, 1'b0, 4'd0, 3'd0, 16'h0},
    '{2'd2, 4'd2, 8'h10, 3'd0, 16'h0,    1'b0, 4'd0, 1'b0, 4'd0, 3'd0, 16'h0},
    '{2'd2, 4'd1, 8'h10, 3'd0, 16'h0,    1'b1, 4'd2, 1'b0, 4'd0, 3'd0, 16'h0},
    '{2'd1, 4'd5, 8'h20, 3'd0, 16'h0,    1'b1, 4'd5, 1'b0, 4'd0, 3'd0, 16'h0},
    '{2'd1, 4'd6, 8'h30, 3'd0, 16'h0,    1'b1, 4'd6, 1'b0, 4'd0, 3'd0, 16'h0},
    '{2'd1, 4'd7, 8'h30, 3'd0, 16'h0,    1'b1, 4'd7, 1'b0, 4'd0, 3'd0, 16'h0},
    '{2'd3, 4'd6, 8'h30, 3'd1, 16'h5555, 1'b0, 4'd0, 1'b0, 4'd0, 3'd0, 16'h0},
    '{2'd3, 4'd9, 8'h10, 3'd1, 16'h6666, 1'b0, 4'd0, 1'b0, 4'd0, 3'd0, 16'h0},
    '{2'd2, 4'd2, 8'h10, 3'd0, 16'h0,    1'b1, 4'd3, 1'b0, 4'd0, 3'd0, 16'h0},
    '{2'd2, 4'd3, 8'h10, 3'd0, 16'h0,    1'b0, 4'd0, 1'b0, 4'd0, 3'd0, 16'h0},
    '{2'd1, 4'd8, 8'h30, 3'd0, 16'h0,    1'b1, 4'd8, 1'b0, 4'd0, 3'd0, 16'h0},
    '{2'd1, 4'd9, 8'h30, 3'd0, 16'h0,    1'b0, 4'd0, 1'b0, 4'd0, 3'd0, 16'h0},
    '{2'd2, 4'd5, 8'h20, 3'd0, 16'h0,    1'b0, 4'd0, 1'b0, 4'd0, 3'd0, 16'h0},
    '{2'd3, 4'd8, 8'h30, 3'd1, 16'h3333, 1'b0, 4'd0, 1'b1, 4'd9, 3'd1, 16'h3333}
  };
  localparam string TAGS [NV] = '{
    "R2", "R3", "R8", "R9", "R9", "R7", "R4", "R4 R12", "R11", "R6",
    "R6", "R10", "R10", "R4 R7", "R5", "R5", "R3", "R5", "R8 R11"
  };

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              msgValid = 1'b0;
  logic [1:0]        msgKind = 2'd0;
  logic [CORE_W-1:0] msgCore = '0;
  logic [ADDR_W-1:0] msgAddr = '0;
  logic [OFF_W-1:0]  msgOff = '0;
  logic [VAL_W-1:0]  msgVal = '0;
  logic              grantValid, fwdValid;
  logic [CORE_W-1:0] grantCore, fwdCore;
  logic [ADDR_W-1:0] grantAddr, fwdAddr;
  logic [OFF_W-1:0]  fwdOff;
  logic [VAL_W-1:0]  fwdVal;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  dq_relay_top #(.NQ(NQ), .DEPTH(DEPTH), .CORE_W(CORE_W), .ADDR_W(ADDR_W),
                 .OFF_W(OFF_W), .VAL_W(VAL_W)) dut_i (
    .clk(clk), .rstN(rstN), .msgValid(msgValid), .msgKind(msgKind),
    .msgCore(msgCore), .msgAddr(msgAddr), .msgOff(msgOff), .msgVal(msgVal),
    .grantValid(grantValid), .grantCore(grantCore), .grantAddr(grantAddr),
    .fwdValid(fwdValid), .fwdCore(fwdCore), .fwdAddr(fwdAddr),
    .fwdOff(fwdOff), .fwdVal(fwdVal));

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // drive on the falling edge, results are registered at the next rising edge
  task automatic send(input vec_t v);
    msgValid = 1'b1;
    msgKind  = v.kind;
    msgCore  = v.core;
    msgAddr  = v.addr;
    msgOff   = v.off;
    msgVal   = v.val;
    @(posedge clk);
    @(negedge clk);
    msgValid = 1'b0;
    msgKind  = 2'd0;
  endtask

  task automatic expect_out(input string tag, input vec_t v);
    chk(tag, "grantValid", 32'(grantValid), 32'(v.eG));
    if (v.eG) begin
      chk(tag, "grantCore", 32'(grantCore), 32'(v.eGc));
      chk(tag, "grantAddr", 32'(grantAddr), 32'(v.addr));
    end
    chk(tag, "fwdValid", 32'(fwdValid), 32'(v.eF));
    if (v.eF) begin
      chk(tag, "fwdCore", 32'(fwdCore), 32'(v.eFc));
      chk(tag, "fwdAddr", 32'(fwdAddr), 32'(v.addr));
      chk(tag, "fwdOff", 32'(fwdOff), 32'(v.eFo));
      chk(tag, "fwdVal", 32'(fwdVal), 32'(v.eFv));
    end
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    vec_t v;
    repeat (2) @(negedge clk);
    // R1: idle outputs under and after reset
    chk("R1", "grantValid in reset", 32'(grantValid), 0);
    chk("R1", "fwdValid in reset", 32'(fwdValid), 0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1", "grantValid after reset", 32'(grantValid), 0);

    for (int i = 0; i < NV; i++) begin
      send(VECS[i]);
      expect_out(TAGS[i], VECS[i]);
    end

    // R13: pulse ends after one cycle with no message
    @(negedge clk);
    chk("R13", "grantValid idle", 32'(grantValid), 0);
    chk("R13", "fwdValid idle", 32'(fwdValid), 0);
    // R13: a message of kind none does nothing
    v = '{2'd0, 4'd1, 8'h40, 3'd0, 16'h0, 1'b0, 4'd0, 1'b0, 4'd0, 3'd0, 16'h0};
    send(v);
    expect_out("R13", v);

    // R1: reset drops the queue still holding address 30; a request then gets a fresh grant
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    v = '{2'd1, 4'd1, 8'h30, 3'd0, 16'h0, 1'b1, 4'd1, 1'b0, 4'd0, 3'd0, 16'h0};
    send(v);
    expect_out("R1", v);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule